// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received frames from a byte stream and stores each one into a memory buffer. The buffer is chosen from a ring of two-word descriptors that software prepares. The first word of a descriptor gives a word-aligned buffer address. Its two low bits are flags: one marks that the descriptor holds a finished frame and belongs to software, the other marks the last descriptor of the ring. The second word receives the frame status: the stored length, a multicast marker and a truncation marker.

At the start of each frame the block reads the first word of the current descriptor. If software still owns that descriptor, the block drops the frame, counts it, raises a buffer-not-available flag and stalls. If the descriptor is free, the block packs the frame bytes into 32-bit words and writes them to the buffer. It then writes the status word, and only after that rewrites the first word with its done flag set. The ring pointer then moves to the next descriptor, or back to the ring base after a descriptor marked as last.

Software leaves the stall by taking the enable input low and then high again. This reloads the pointer from the ring base. Two interrupt sources are held in a status register that clears when read, and each source has its own enable bit behind separate set and clear strobes.

Top module: `rxring_writer`

## Requirements
- R1: After reset, in_ready, mem_rd and mem_wr are low, isr_val, ien_val and irq are zero, and drop_count is zero.
- R2: A frame that starts while enabled and not stalled causes one read of the first word at the current descriptor address. Bit 0 of that word is the done flag, bit 1 is the last-in-ring flag, and the word with bits 1:0 cleared is the buffer address.
- R3: Frame byte k is stored at buffer address + k, packed little-endian: byte 4j+i of the frame goes to bits 8i+7:8i of buffer word j. Unused bytes of the final word are written as zero.
- R4: After the data, the status word is written to descriptor address + 4. It holds the stored byte count in bits 10:0, in_mcast (sampled with the last byte) in bit 12, the truncation flag in bit 13, and zero elsewhere. Only after that is the first word rewritten as its fetched value with bit 0 set.
- R5: A frame longer than MAX_BYTES (default 1536) has only its first MAX_BYTES bytes stored. Its status word reports MAX_BYTES as the length and sets bit 13.
- R6: After a frame is stored, the next descriptor is at the current address + 8. If the used descriptor had bit 1 set, the next descriptor is at ring_base with bits 2:0 cleared.
- R7: If the fetched first word has bit 0 set, the frame is consumed without any memory write, isr bit 1 is set and drop_count increments. The block then stalls: every later frame is consumed, counted and flagged the same way with no memory access at all.
- R8: While rx_en is low and no frame is in progress, the pointer is held at ring_base (bits 2:0 cleared) and the stall is cleared. A frame arriving while rx_en is low is consumed with no memory access, no flag and no count.
- R9: isr_val bit 0 is set when a frame has been stored, and bit 1 as stated in R7, whatever the enable bits are. A pulse on isr_read clears both bits; an event in the same cycle stays set.
- R10: ien_set sets enable bits and ien_clr clears them (clear wins if both are pulsed together). irq is high exactly when some isr_val bit and its enable bit are both set.
- R11: drop_count saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable; a low period restarts the ring |
| ring_base | input | AW | Address of the first descriptor of the ring |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_mcast | input | 1 | Multicast destination marker, sampled with the final byte |
| in_ready | output | 1 | Byte accepted on this clock edge when high together with in_valid |
| mem_rd | output | 1 | Memory read request, data returned the following cycle |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| isr_read | input | 1 | Read strobe that clears the interrupt status |
| ien_set | input | 2 | Per-source enable set strobes |
| ien_clr | input | 2 | Per-source enable clear strobes |
| isr_val | output | 2 | Interrupt status: bit 0 frame stored, bit 1 buffer not available |
| ien_val | output | 2 | Interrupt enable bits |
| irq | output | 1 | Interrupt request |
| drop_count | output | CNT_W | Saturating count of dropped frames |

## Verification
Frames of 5, 8 and 1540 bytes exercise the main path. They distinguish a partial final word from an exact word boundary, and a normal frame from a truncated one. They also separate a plain descriptor from one marked last in the ring, and a unicast frame from a multicast one. Frames that reach a descriptor still owned by software show the difference between the first drop, which costs one read, and later drops while stalled, which cost none. Moving the ring base before a restart shows that the pointer is reloaded rather than kept. A frame sent while disabled must leave memory, flags and counter untouched.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
    localparam int DONE_BIT       = 0;
    localparam int WRAP_BIT       = 1;
    localparam int STAT_MCAST_BIT = 12;
    localparam int STAT_LONG_BIT  = 13;
    localparam int NUM_SRC        = 2;
    localparam int SRC_STORED     = 0;
    localparam int SRC_NOBUF      = 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RDWAIT,
        S_CHECK,
        S_RECV,
        S_STATUS,
        S_DONEWR,
        S_DISCARD
    } rx_state_e;
endpackage

// File: rtl/rxring_fsm.sv
module rxring_fsm
    import rxring_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MAX_BYTES = 1536
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic [AW-1:0] ring_base,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          in_mcast,
    output logic          in_ready,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          ev_stored,
    output logic          ev_nobuf
);
    localparam int LEN_W = $clog2(MAX_BYTES + 1);

    typedef struct packed {
        rx_state_e      st;
        logic [AW-1:0]  ptr;
        logic [AW-1:0]  bufa;
        logic [31:0]    word0;
        logic [31:0]    wbuf;
        logic [LEN_W-1:0] len;
        logic           trunc;
        logic           mcast;
        logic           stalled;
        logic           rd;
        logic           wr;
        logic [AW-1:0]  addr;
        logic [31:0]    wdata;
        logic           ev_st;
        logic           ev_nb;
    } fsm_t;

    fsm_t q, d;
    logic [AW-1:0] base_al;

    assign base_al = ring_base & ~AW'(7);

    always_comb begin
        logic [1:0]  idx;
        logic [31:0] wv;
        logic [31:0] stat;
        idx  = q.len[1:0];
        wv   = '0;
        stat = '0;
        d       = q;
        d.rd    = 1'b0;
        d.wr    = 1'b0;
        d.ev_st = 1'b0;
        d.ev_nb = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (!rx_en) begin
                    d.ptr     = base_al;
                    d.stalled = 1'b0;
                    if (in_valid) d.st = S_DISCARD;
                end else if (in_valid) begin
                    if (q.stalled) begin
                        d.ev_nb = 1'b1;
                        d.st    = S_DISCARD;
                    end else begin
                        d.rd   = 1'b1;
                        d.addr = q.ptr;
                        d.st   = S_RDWAIT;
                    end
                end
            end
            S_RDWAIT: d.st = S_CHECK;
            S_CHECK: begin
                if (mem_rdata[DONE_BIT]) begin
                    d.ev_nb   = 1'b1;
                    d.stalled = 1'b1;
                    d.st      = S_DISCARD;
                end else begin
                    d.word0 = mem_rdata;
                    d.bufa  = AW'(mem_rdata & ~32'h3);
                    d.len   = '0;
                    d.trunc = 1'b0;
                    d.mcast = 1'b0;
                    d.st    = S_RECV;
                end
            end
            S_RECV: begin
                if (in_valid) begin
                    if (q.len < LEN_W'(MAX_BYTES)) begin
                        wv = (idx == 2'd0) ? 32'h0 : q.wbuf;
                        wv[{idx, 3'b000} +: 8] = in_data;
                        d.wbuf = wv;
                        if (idx == 2'd3 || in_last) begin
                            d.wr    = 1'b1;
                            d.addr  = q.bufa + (AW'(q.len) & ~AW'(3));
                            d.wdata = wv;
                        end
                        d.len = q.len + 1'b1;
                    end else begin
                        d.trunc = 1'b1;
                    end
                    if (in_last) begin
                        d.mcast = in_mcast;
                        d.st    = S_STATUS;
                    end
                end
            end
            S_STATUS: begin
                stat[LEN_W-1:0]      = q.len;
                stat[STAT_MCAST_BIT] = q.mcast;
                stat[STAT_LONG_BIT]  = q.trunc;
                d.wr    = 1'b1;
                d.addr  = q.ptr + AW'(4);
                d.wdata = stat;
                d.st    = S_DONEWR;
            end
            S_DONEWR: begin
                d.wr    = 1'b1;
                d.addr  = q.ptr;
                d.wdata = q.word0 | (32'h1 << DONE_BIT);
                d.ev_st = 1'b1;
                d.ptr   = q.word0[WRAP_BIT] ? base_al : q.ptr + AW'(8);
                d.st    = S_IDLE;
            end
            S_DISCARD: begin
                if (in_valid && in_last) d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready  = (q.st == S_RECV) || (q.st == S_DISCARD);
    assign mem_rd    = q.rd;
    assign mem_wr    = q.wr;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;
    assign ev_stored = q.ev_st;
    assign ev_nobuf  = q.ev_nb;

    // R2
    single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R3
    aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr[1:0] == 2'b00));

    // R7
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.stalled |-> (!mem_wr && !mem_rd));

    // R4
    done_after_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stored |-> (mem_wr && $past(mem_wr) && (mem_addr + AW'(4) == $past(mem_addr))));
endmodule

// File: rtl/rxring_irq.sv
module rxring_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         rd,
    input  logic [N-1:0] en_set,
    input  logic [N-1:0] en_clr,
    output logic [N-1:0] isr,
    output logic [N-1:0] ien,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] isr;
        logic [N-1:0] ien;
    } irq_t;

    irq_t q, d;
    logic [N-1:0] isr_nx, ien_nx;

    for (genvar i = 0; i < N; i++) begin : g_src
        assign isr_nx[i] = ev[i] | (q.isr[i] & ~rd);
        assign ien_nx[i] = (q.ien[i] | en_set[i]) & ~en_clr[i];
    end

    always_comb begin
        d     = q;
        d.isr = isr_nx;
        d.ien = ien_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign isr = q.isr;
    assign ien = q.ien;
    assign irq = |(q.isr & q.ien);

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ev == '0) |=> (isr == '0));

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr != '0) |=> ((ien & $past(en_clr)) == '0));
endmodule

// File: rtl/rxring_dropcnt.sv
module rxring_dropcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d = q;
        if (inc && (q.cnt != '1)) d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count = q.cnt;

    // R11
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count >= $past(count));
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
    import rxring_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MAX_BYTES = 1536,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic [AW-1:0]    ring_base,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             in_mcast,
    output logic             in_ready,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             isr_read,
    input  logic [1:0]       ien_set,
    input  logic [1:0]       ien_clr,
    output logic [1:0]       isr_val,
    output logic [1:0]       ien_val,
    output logic             irq,
    output logic [CNT_W-1:0] drop_count
);
    logic ev_stored, ev_nobuf;
    logic [NUM_SRC-1:0] ev_vec;

    assign ev_vec[SRC_STORED] = ev_stored;
    assign ev_vec[SRC_NOBUF]  = ev_nobuf;

    rxring_fsm #(.AW(AW), .MAX_BYTES(MAX_BYTES)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .ring_base (ring_base),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_mcast  (in_mcast),
        .in_ready  (in_ready),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .ev_stored (ev_stored),
        .ev_nobuf  (ev_nobuf)
    );

    rxring_irq #(.N(NUM_SRC)) irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_vec),
        .rd     (isr_read),
        .en_set (ien_set),
        .en_clr (ien_clr),
        .isr    (isr_val),
        .ien    (ien_val),
        .irq    (irq)
    );

    rxring_dropcnt #(.W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ev_nobuf),
        .count (drop_count)
    );
endmodule

// File: tb/rxring_writer_tb_top.sv
module rxring_writer_tb_top;
    localparam int CW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic [31:0] ring_base = 32'h100;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_mcast = 1'b0;
    logic        in_ready;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        isr_read = 1'b0;
    logic [1:0]  ien_set = '0, ien_clr = '0;
    logic [1:0]  isr_val, ien_val;
    logic        irq;
    logic [CW-1:0] drop_count;

    int n_chk = 0, n_err = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [31:0] mem [0:2047];

    always #2 clk = ~clk;

    rxring_writer #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_mcast(in_mcast),
        .in_ready(in_ready), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .isr_read(isr_read),
        .ien_set(ien_set), .ien_clr(ien_clr), .isr_val(isr_val), .ien_val(ien_val),
        .irq(irq), .drop_count(drop_count)
    );

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[12:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[12:2]];
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mw(input logic [31:0] a);
        return mem[a[12:2]];
    endfunction

    function automatic logic [31:0] exp_word(input logic [7:0] seed, input int n, input int j);
        logic [31:0] w = '0;
        for (int i = 0; i < 4; i++)
            if (4*j + i < n) w[8*i +: 8] = seed + 8'(4*j + i);
        return w;
    endfunction

    task automatic send_frame(input int n, input logic [7:0] seed, input logic mc);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = seed + 8'(k);
            in_last  = (k == n - 1);
            in_mcast = mc;
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_mcast = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_buffer(input string req, input logic [31:0] bufa, input int n, input logic [7:0] seed);
        int stored = (n > 1536) ? 1536 : n;
        int bad = 0;
        logic [31:0] a_act = '0, a_exp = '0;
        for (int j = 0; j < (stored + 3) / 4; j++)
            if (mw(bufa + 32'(4*j)) !== exp_word(seed, stored, j) && bad == 0) begin
                bad = 1;
                a_act = mw(bufa + 32'(4*j));
                a_exp = exp_word(seed, stored, j);
            end
        chk(req, "buffer contents", a_act, a_exp);
    endtask

    task automatic pulse_isr_read();
        @(negedge clk); isr_read = 1'b1;
        @(negedge clk); isr_read = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "in_ready", 32'(in_ready), 0);
        chk("R1", "mem_rd|mem_wr", 32'(mem_rd | mem_wr), 0);
        chk("R1", "isr/ien/irq", {27'b0, isr_val, ien_val, irq}, 0);
        chk("R1", "drop_count", 32'(drop_count), 0);
    endtask

    task automatic t_first_frame();
        int r0 = rd_cnt, w0 = wr_cnt;
        send_frame(5, 8'h10, 1'b0);
        chk("R2", "descriptor reads", 32'(rd_cnt - r0), 1);
        chk("R3", "buffer word 0", mw(32'h400), 32'h13121110);
        chk("R3", "partial word zero fill", mw(32'h404), 32'h00000014);
        chk("R4", "status word", mw(32'h104), 32'h5);
        chk("R4", "word0 done", mw(32'h100), 32'h401);
        chk("R4", "write count", 32'(wr_cnt - w0), 4);
        chk("R9", "stored flag", 32'(isr_val), 32'h1);
        pulse_isr_read();
        chk("R9", "isr cleared by read", 32'(isr_val), 0);
    endtask

    task automatic t_mcast_frame();
        send_frame(8, 8'h40, 1'b1);
        check_buffer("R3", 32'h1000, 8, 8'h40);
        chk("R4", "status with multicast", mw(32'h10C), 32'h1008);
        chk("R6", "second descriptor done", mw(32'h108), 32'h1001);
    endtask

    task automatic t_long_frame();
        send_frame(1540, 8'h80, 1'b0);
        check_buffer("R5", 32'h1800, 1540, 8'h80);
        chk("R5", "word after buffer untouched", mw(32'h1E00), 32'hA5A5A5A5);
        chk("R5", "status truncated", mw(32'h114), 32'h2600);
        chk("R6", "last descriptor done", mw(32'h110), 32'h1803);
    endtask

    task automatic t_no_buffer();
        int r0 = rd_cnt, w0 = wr_cnt;
        send_frame(3, 8'h50, 1'b0);
        chk("R6", "wrap read at base", 32'(rd_cnt - r0), 1);
        chk("R7", "no writes on drop", 32'(wr_cnt - w0), 0);
        chk("R7", "drop count 1", 32'(drop_count), 1);
        chk("R7", "nobuf flag", 32'(isr_val[1]), 1);
        chk("R7", "owned descriptor untouched", mw(32'h104), 32'h5);
        r0 = rd_cnt;
        send_frame(2, 8'h58, 1'b0);
        chk("R7", "stalled frame no read", 32'(rd_cnt - r0), 0);
        chk("R7", "drop count 2", 32'(drop_count), 2);
    endtask

    task automatic t_saturate();
        for (int f = 0; f < 6; f++) send_frame(1, 8'h00, 1'b0);
        chk("R11", "drop count saturates", 32'(drop_count), 7);
    endtask

    task automatic t_restart();
        pulse_isr_read();
        ring_base = 32'h10F;
        mem[32'h108 >> 2] = 32'h1000;
        @(negedge clk); rx_en = 1'b0;
        repeat (2) @(negedge clk);
        rx_en = 1'b1;
        send_frame(4, 8'h20, 1'b0);
        chk("R8", "restart lands at new base", mw(32'h1000), 32'h23222120);
        chk("R8", "restart status", mw(32'h10C), 32'h4);
        chk("R8", "stall cleared", 32'(isr_val), 32'h1);
    endtask

    task automatic t_disabled();
        int r0, w0;
        @(negedge clk); rx_en = 1'b0;
        pulse_isr_read();
        r0 = rd_cnt; w0 = wr_cnt;
        send_frame(6, 8'h70, 1'b0);
        chk("R8", "disabled frame no memory access", 32'(rd_cnt - r0 + wr_cnt - w0), 0);
        chk("R8", "disabled frame no flag", 32'(isr_val), 0);
        chk("R8", "disabled frame no count", 32'(drop_count), 7);
        rx_en = 1'b1;
    endtask

    task automatic t_irq_mask();
        mem[32'h108 >> 2] = 32'h1000;
        @(negedge clk); ien_set = 2'b01;
        @(negedge clk); ien_set = 2'b00;
        chk("R10", "enable set", 32'(ien_val), 32'h1);
        send_frame(2, 8'h60, 1'b0);
        chk("R8", "pointer reloaded to base", mw(32'h1000), 32'h00006160);
        chk("R10", "irq raised", 32'(irq), 1);
        pulse_isr_read();
        chk("R10", "irq drops after read", 32'(irq), 0);
        @(negedge clk); ien_clr = 2'b01; ien_set = 2'b11;
        @(negedge clk); ien_clr = 2'b00; ien_set = 2'b00;
        chk("R10", "clear wins over set", 32'(ien_val), 32'h2);
        mem[32'h110 >> 2] = 32'h1802;
        send_frame(3, 8'h30, 1'b0);
        chk("R9", "flag set while masked", 32'(isr_val), 32'h1);
        chk("R10", "masked source no irq", 32'(irq), 0);
        chk("R6", "after wrap at moved base", 32'(mw(32'h110)), 32'h1803);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
        mem[32'h100 >> 2] = 32'h400;
        mem[32'h108 >> 2] = 32'h1000;
        mem[32'h110 >> 2] = 32'h1802;
        mem[32'h1E00 >> 2] = 32'hA5A5A5A5;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);
        t_first_frame();
        t_mcast_frame();
        t_long_frame();
        t_no_buffer();
        t_saturate();
        t_restart();
        t_disabled();
        t_irq_mask();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule